// File: doc/BRIEF.md
# Track Format Byte Translator

This block carries the byte stream of a whole-track format command. When a command is accepted, it asks the host for the first byte at once. It then waits for the index pulse and writes one byte per byte-time tick until a programmed track length has been written. Each slot's byte comes from a single holding register that the host fills through a request/strobe handshake. If the host has not refilled the register by the next slot, a zero byte is written and a sticky lost-data flag is raised.

Three host code values are not written as they are. One becomes an 0xA1 sync byte with a missing clock, and it also presets the running CRC. One becomes an 0xC2 sync byte with a missing clock. The third emits the two-byte CRC over the following two slots, high byte first, and no host request is raised for the low-byte slot. An 0xFE that directly follows a translated 0xA1 is marked as an ID address mark. The bit-level recording encoding and the storage medium sit downstream and are outside this block.

Top module: `fmt_track_writer`

## Requirements
- R1: A start pulse in idle sets busy and raises the data request in the next cycle, before any index pulse. It also clears lost data and the interrupt request. A start pulse while busy has no effect: a host byte already latched survives it and is written in the first slot.
- R2: If no host byte has been latched when the index pulse arrives, the command sets lost data and the interrupt request, clears busy and the data request, and writes no byte.
- R3: A host byte of 0xF5 is written as 0xA1 with the missing-clock flag set. The CRC is first preset to its value after two 0xA1 bytes from 0xFFFF, and is then updated with 0xA1.
- R4: A host byte of 0xF6 is written as 0xC2 with the missing-clock flag set, and 0xC2 updates the CRC.
- R5: A host byte of 0xF7 writes the CRC high byte in its slot and the CRC low byte in the next slot. The data request stays low during that next slot, and neither CRC byte updates the CRC.
- R6: The ID-mark flag is set only for a written 0xFE whose preceding slot was a translated 0xF5.
- R7: When a slot needs a host byte and none was latched, 0x00 is written in that slot and lost data is set until the next start.
- R8: After the index pulse, exactly track_len_i bytes are written, one per tick. The last one clears busy and the data request and sets the interrupt request.
- R9: Any other byte is written unchanged without the missing-clock flag. It updates a CRC with polynomial 0x1021, preset 0xFFFF, processed most significant bit first.
- R10: Each written byte shows up on wr_data_o with wr_en_o high for one cycle, in the cycle after the tick. A host strobe while the data request is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Command accepted pulse |
| tick_i | input | 1 | One pulse per byte-time |
| index_i | input | 1 | Index pulse, starts the track |
| track_len_i | input | LEN_W | Bytes per track, sampled at the index pulse, nonzero |
| host_data_i | input | 8 | Host byte |
| host_wr_i | input | 1 | Host byte strobe |
| wr_data_o | output | 8 | Byte written to the track |
| wr_en_o | output | 1 | Byte valid for one cycle |
| mclk_o | output | 1 | Byte is a missing-clock sync byte |
| idam_o | output | 1 | Byte is an ID address mark |
| drq_o | output | 1 | Host byte requested |
| lost_o | output | 1 | Sticky lost-data flag |
| busy_o | output | 1 | Command in progress |
| irq_o | output | 1 | Command finished |

## Verification
On every cycle the assertions check several invariants. The request only appears while busy, and it is always low during a CRC low-byte slot. The marker flags only accompany written bytes of the right value, and a write only follows a tick in the running state. A missing first byte ends the command without any write. The completion edge leaves the block idle with the request cleared. Only the bench scenarios can show that byte values, CRC contents and the count of written bytes are right, because these depend on the whole history of host bytes, missed requests and ignored strobes, which the bench replays through its own model.

// File: rtl/fmt_pkg.sv
// Shared types and constants for the track format byte translator.
// Assumes CRC is processed MSB first with a 0xFFFF preset.
package fmt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_IDX,
        ST_RUN
    } fmt_state_e;

    localparam logic [15:0] CRC_INIT = 16'hFFFF;
    localparam logic [15:0] CRC_POLY = 16'h1021;

    localparam logic [7:0] CODE_SYNC_A1 = 8'hF5;
    localparam logic [7:0] CODE_SYNC_C2 = 8'hF6;
    localparam logic [7:0] CODE_CRC     = 8'hF7;
    localparam logic [7:0] BYTE_A1      = 8'hA1;
    localparam logic [7:0] BYTE_C2      = 8'hC2;
    localparam logic [7:0] BYTE_IDAM    = 8'hFE;

    // One byte of CRC update, MSB first.
    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        logic        fb;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            fb = r[15] ^ d[i];
            r  = {r[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
        end
        return r;
    endfunction

    localparam logic [15:0] CRC_AFTER_TWO_SYNC = crc_step(crc_step(CRC_INIT, BYTE_A1), BYTE_A1);

endpackage

// File: rtl/fmt_crc.sv
// Running CRC register for the track byte stream.
// Assumes: clear has priority; preset loads the two-sync value and then folds din in.
module fmt_crc
    import fmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        en,
    input  logic        preset,
    input  logic        feed,
    input  logic [7:0]  din,
    output logic [15:0] crc
);

    // Hold, clear, preset-and-update or update the CRC once per written slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc <= CRC_INIT;
        end else if (clear) begin
            crc <= CRC_INIT;
        end else if (en && preset) begin
            crc <= crc_step(CRC_AFTER_TWO_SYNC, din);
        end else if (en && feed) begin
            crc <= crc_step(crc, din);
        end
    end

endmodule

// File: rtl/fmt_xlate.sv
// Combinational translation of the slot byte into the written byte and its flags.
// Assumes: cur_is_crc_lo overrides any code decoding of cur.
module fmt_xlate
    import fmt_pkg::*;
(
    input  logic [7:0]  cur,
    input  logic        cur_is_crc_lo,
    input  logic        prev_sync,
    input  logic [15:0] crc,
    output logic [7:0]  out_byte,
    output logic        mclk,
    output logic        sync_a1,
    output logic        crc_hi,
    output logic        feed,
    output logic        preset,
    output logic        idam
);

    // Decode host codes into written byte, marker flags and CRC control.
    always_comb begin
        out_byte = cur;
        mclk     = 1'b0;
        sync_a1  = 1'b0;
        crc_hi   = 1'b0;
        feed     = 1'b0;
        preset   = 1'b0;
        idam     = 1'b0;
        if (cur_is_crc_lo) begin
            out_byte = crc[7:0];
        end else begin
            case (cur)
                CODE_SYNC_A1: begin
                    out_byte = BYTE_A1;
                    mclk     = 1'b1;
                    sync_a1  = 1'b1;
                    preset   = 1'b1;
                end
                CODE_SYNC_C2: begin
                    out_byte = BYTE_C2;
                    mclk     = 1'b1;
                    feed     = 1'b1;
                end
                CODE_CRC: begin
                    out_byte = crc[15:8];
                    crc_hi   = 1'b1;
                end
                default: begin
                    feed = 1'b1;
                    idam = (cur == BYTE_IDAM) && prev_sync;
                end
            endcase
        end
    end

endmodule

// File: rtl/fmt_track_writer.sv
// Format-command byte path: host handshake, index wait, per-tick byte emission.
// Assumes: track_len_i is nonzero and stable at the index pulse; one tick per byte-time.
module fmt_track_writer
    import fmt_pkg::*;
#(
    parameter int LEN_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             tick_i,
    input  logic             index_i,
    input  logic [LEN_W-1:0] track_len_i,
    input  logic [7:0]       host_data_i,
    input  logic             host_wr_i,
    output logic [7:0]       wr_data_o,
    output logic             wr_en_o,
    output logic             mclk_o,
    output logic             idam_o,
    output logic             drq_o,
    output logic             lost_o,
    output logic             busy_o,
    output logic             irq_o
);

    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

    fmt_state_e       state;
    logic [7:0]       hold;
    logic             have_hold;
    logic [7:0]       cur;
    logic             cur_crc_lo;
    logic             prev_sync;
    logic [LEN_W-1:0] remain;
    logic             drq_q;

    logic             host_take;
    logic             eff_have;
    logic [7:0]       eff_data;
    logic             slot;
    logic             crc_clear;
    logic [15:0]      crc;
    logic [7:0]       x_byte;
    logic             x_mclk, x_sync, x_hi, x_feed, x_preset, x_idam;

    // Handshake view: a strobe counts only while requested; same-cycle strobe counts as latched.
    always_comb begin
        host_take = host_wr_i && drq_q;
        eff_have  = have_hold || host_take;
        eff_data  = host_take ? host_data_i : hold;
        slot      = (state == ST_RUN) && tick_i;
        crc_clear = (state == ST_IDLE) && start_i;
    end

    fmt_xlate u_xlate (
        .cur           (cur),
        .cur_is_crc_lo (cur_crc_lo),
        .prev_sync     (prev_sync),
        .crc           (crc),
        .out_byte      (x_byte),
        .mclk          (x_mclk),
        .sync_a1       (x_sync),
        .crc_hi        (x_hi),
        .feed          (x_feed),
        .preset        (x_preset),
        .idam          (x_idam)
    );

    fmt_crc u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (crc_clear),
        .en     (slot),
        .preset (x_preset),
        .feed   (x_feed),
        .din    (x_byte),
        .crc    (crc)
    );

    // Command sequencing, host holding register and per-slot byte output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            hold       <= 8'h00;
            have_hold  <= 1'b0;
            cur        <= 8'h00;
            cur_crc_lo <= 1'b0;
            prev_sync  <= 1'b0;
            remain     <= '0;
            drq_q      <= 1'b0;
            lost_o     <= 1'b0;
            irq_o      <= 1'b0;
            wr_data_o  <= 8'h00;
            wr_en_o    <= 1'b0;
            mclk_o     <= 1'b0;
            idam_o     <= 1'b0;
        end else begin
            wr_en_o <= 1'b0;
            mclk_o  <= 1'b0;
            idam_o  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        state     <= ST_WAIT_IDX;
                        drq_q     <= 1'b1;
                        lost_o    <= 1'b0;
                        irq_o     <= 1'b0;
                        have_hold <= 1'b0;
                    end
                end
                ST_WAIT_IDX: begin
                    if (host_take) begin
                        hold      <= host_data_i;
                        have_hold <= 1'b1;
                        drq_q     <= 1'b0;
                    end
                    if (index_i) begin
                        if (eff_have) begin
                            state      <= ST_RUN;
                            cur        <= eff_data;
                            cur_crc_lo <= 1'b0;
                            prev_sync  <= 1'b0;
                            have_hold  <= 1'b0;
                            drq_q      <= 1'b1;
                            remain     <= track_len_i;
                        end else begin
                            state  <= ST_IDLE;
                            lost_o <= 1'b1;
                            irq_o  <= 1'b1;
                            drq_q  <= 1'b0;
                        end
                    end
                end
                ST_RUN: begin
                    if (slot) begin
                        wr_en_o   <= 1'b1;
                        wr_data_o <= x_byte;
                        mclk_o    <= x_mclk;
                        idam_o    <= x_idam;
                        prev_sync <= x_sync;
                        if (remain == LEN_ONE) begin
                            state     <= ST_IDLE;
                            drq_q     <= 1'b0;
                            irq_o     <= 1'b1;
                            have_hold <= 1'b0;
                        end else begin
                            remain <= remain - LEN_ONE;
                            if (x_hi) begin
                                cur_crc_lo <= 1'b1;
                                drq_q      <= 1'b0;
                                if (host_take) begin
                                    hold      <= host_data_i;
                                    have_hold <= 1'b1;
                                end
                            end else begin
                                cur_crc_lo <= 1'b0;
                                drq_q      <= 1'b1;
                                have_hold  <= 1'b0;
                                if (eff_have) begin
                                    cur <= eff_data;
                                end else begin
                                    cur    <= 8'h00;
                                    lost_o <= 1'b1;
                                end
                            end
                        end
                    end else if (host_take) begin
                        hold      <= host_data_i;
                        have_hold <= 1'b1;
                        drq_q     <= 1'b0;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign drq_o  = drq_q;
    assign busy_o = (state != ST_IDLE);

    AST_DRQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        drq_o |-> busy_o); // R1

    AST_NO_WRITE_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_IDX && index_i && !eff_have) |=> (!wr_en_o && lost_o && !busy_o)); // R2

    AST_MCLK_SYNC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        mclk_o |-> (wr_en_o && (wr_data_o == BYTE_A1 || wr_data_o == BYTE_C2))); // R4

    AST_CRC_LO_NO_DRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && cur_crc_lo) |-> !drq_o); // R5

    AST_IDAM_ON_FE: assert property (@(posedge clk) disable iff (!rst_n)
        idam_o |-> (wr_en_o && wr_data_o == BYTE_IDAM && !mclk_o)); // R6

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (!busy_o && !drq_o)); // R8

    AST_REMAIN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> (remain != '0)); // R8

    AST_WRITE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> $past(state == ST_RUN && tick_i)); // R10

endmodule

// File: tb/tb_fmt_track_writer.sv
module tb_fmt_track_writer;

    localparam int LEN_W = 14;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             tick_i = 1'b0;
    logic             index_i = 1'b0;
    logic [LEN_W-1:0] track_len_i = '0;
    logic [7:0]       host_data_i = 8'h00;
    logic             host_wr_i = 1'b0;
    logic [7:0]       wr_data_o;
    logic             wr_en_o, mclk_o, idam_o, drq_o, lost_o, busy_o, irq_o;

    int checks = 0;
    int fails  = 0;

    logic [7:0] hb   [0:63];
    bit         miss [0:63];
    bit         junk [0:63];

    always #4 clk = ~clk;

    fmt_track_writer #(.LEN_W(LEN_W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .tick_i(tick_i),
        .index_i(index_i), .track_len_i(track_len_i), .host_data_i(host_data_i),
        .host_wr_i(host_wr_i), .wr_data_o(wr_data_o), .wr_en_o(wr_en_o),
        .mclk_o(mclk_o), .idam_o(idam_o), .drq_o(drq_o), .lost_o(lost_o),
        .busy_o(busy_o), .irq_o(irq_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference CRC: polynomial 0x1021, MSB first.
    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] v;
        v = c ^ {d, 8'h00};
        for (int b = 0; b < 8; b++)
            v = v[15] ? ((v << 1) ^ 16'h1021) : (v << 1);
        return v;
    endfunction

    task automatic pulse_start();
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    endtask
    task automatic pulse_index();
        index_i = 1'b1; @(negedge clk); index_i = 1'b0;
    endtask
    task automatic pulse_tick();
        tick_i = 1'b1; @(negedge clk); tick_i = 1'b0;
    endtask
    task automatic host_write(input logic [7:0] d);
        host_data_i = d; host_wr_i = 1'b1; @(negedge clk); host_wr_i = 1'b0;
    endtask

    // Runs one format command of len slots with hb/miss/junk and checks every slot.
    task automatic run_cmd(input int len);
        int          k;
        logic [7:0]  cur, pend, e_byte;
        bit          curlo, prev_a1, exp_drq, have, exp_lost, e_mclk, e_idam, hi;
        logic [15:0] crc;
        track_len_i = LEN_W'(len);
        pulse_start();
        chk(drq_o && busy_o && !irq_o, "R1 drq before index", {drq_o, busy_o, irq_o}, 3'b110);
        host_write(hb[0]);
        k = 1;
        pulse_index();
        crc = 16'hFFFF; cur = hb[0]; curlo = 0; prev_a1 = 0;
        exp_drq = 1; have = 0; exp_lost = 0; pend = 8'h00;
        for (int i = 0; i < len; i++) begin
            chk(drq_o == exp_drq, curlo ? "R5 no drq on crc low slot" : "R7 drq per slot", drq_o, exp_drq);
            if (exp_drq && !miss[i]) begin
                host_write(hb[k]); pend = hb[k]; k++; have = 1; exp_drq = 0;
                if (junk[i]) host_write(8'h55); // R10 strobe without request ignored
            end else if (!exp_drq && junk[i]) begin
                host_write(8'h55); // R10
            end
            pulse_tick();
            e_mclk = 0; e_idam = 0; hi = 0;
            if (curlo) begin
                e_byte = crc[7:0];
                prev_a1 = 0;
            end else begin
                case (cur)
                    8'hF5: begin
                        e_byte = 8'hA1; e_mclk = 1;
                        crc = ref_crc(ref_crc(ref_crc(16'hFFFF, 8'hA1), 8'hA1), 8'hA1);
                    end
                    8'hF6: begin e_byte = 8'hC2; e_mclk = 1; crc = ref_crc(crc, 8'hC2); end
                    8'hF7: begin e_byte = crc[15:8]; hi = 1; end
                    default: begin
                        e_byte = cur; e_idam = (cur == 8'hFE) && prev_a1;
                        crc = ref_crc(crc, cur);
                    end
                endcase
                prev_a1 = (cur == 8'hF5);
            end
            chk(wr_en_o == 1'b1, "R10 write strobe", wr_en_o, 1);
            chk(wr_data_o == e_byte, "R9 R3 R4 R5 written byte", wr_data_o, e_byte);
            chk(mclk_o == e_mclk, "R3 R4 missing clock", mclk_o, e_mclk);
            chk(idam_o == e_idam, "R6 id mark", idam_o, e_idam);
            if (i != len - 1) begin
                if (hi) begin
                    curlo = 1; exp_drq = 0;
                end else begin
                    curlo = 0; exp_drq = 1;
                    if (have) begin cur = pend; have = 0; end
                    else begin cur = 8'h00; exp_lost = 1; end
                end
            end
        end
        chk(!busy_o && irq_o && !drq_o, "R8 end of track", {busy_o, irq_o, drq_o}, 3'b010);
        chk(lost_o == exp_lost, "R7 lost data", lost_o, exp_lost);
        pulse_tick();
        chk(!wr_en_o, "R8 no byte after track", wr_en_o, 0);
    endtask

    function automatic logic [7:0] pick_byte();
        case ($urandom % 8)
            0: return 8'hF5;
            1: return 8'hF6;
            2: return 8'hF7;
            3: return 8'hFE;
            default: return 8'($urandom);
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !drq_o && !irq_o && !lost_o && !wr_en_o, "R1 reset state",
            {busy_o, drq_o, irq_o, lost_o, wr_en_o}, 0);

        // R2: index arrives with no host byte
        track_len_i = LEN_W'(4);
        pulse_start();
        chk(drq_o && busy_o, "R1 drq raised at start", {drq_o, busy_o}, 2'b11);
        pulse_index();
        chk(lost_o && irq_o && !busy_o && !drq_o, "R2 missing first byte",
            {lost_o, irq_o, busy_o, drq_o}, 4'b1100);
        pulse_tick();
        chk(!wr_en_o, "R2 nothing written", wr_en_o, 0);

        // R1: restart while busy is ignored, latched byte survives
        track_len_i = LEN_W'(1);
        pulse_start();
        host_write(8'h4E);
        pulse_start();
        pulse_index();
        chk(!lost_o && busy_o && !irq_o, "R1 start while busy ignored", {lost_o, busy_o, irq_o}, 3'b010);
        pulse_tick();
        chk(wr_en_o && wr_data_o == 8'h4E, "R1 latched byte written", wr_data_o, 8'h4E);
        chk(irq_o && !busy_o, "R8 one-byte track done", {irq_o, busy_o}, 2'b10);

        // Directed: sync run, ID mark, CRC pair, C2, FE after non-A1
        for (int j = 0; j < 64; j++) begin hb[j] = 8'h4E; miss[j] = 0; junk[j] = 0; end
        hb[0] = 8'h4E; hb[1] = 8'hF5; hb[2] = 8'hF5; hb[3] = 8'hF5; hb[4] = 8'hFE;
        hb[5] = 8'h01; hb[6] = 8'h00; hb[7] = 8'h03; hb[8] = 8'h02; hb[9] = 8'hF7;
        hb[10] = 8'hF6; hb[11] = 8'hFE; hb[12] = 8'hF5; hb[13] = 8'hF7;
        run_cmd(16);

        // Directed: missed requests, strobes without request, CRC in final slot
        for (int j = 0; j < 64; j++) begin hb[j] = 8'($urandom); miss[j] = 0; junk[j] = 0; end
        hb[2] = 8'hF7; miss[4] = 1; junk[2] = 1; junk[3] = 1; junk[5] = 1; hb[6] = 8'hF7;
        run_cmd(8);

        // Random commands
        for (int r = 0; r < 24; r++) begin
            for (int j = 0; j < 64; j++) begin
                hb[j]   = pick_byte();
                miss[j] = ($urandom % 8) == 0;
                junk[j] = ($urandom % 6) == 0;
            end
            run_cmd(2 + int'($urandom % 40));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule